// File: doc/BRIEF.md
# SPI Bit-Clock Divider with Programmable Duty

This block derives an SPI serial clock from the system clock. A single 32-bit configuration word selects the timing. A prescaler divides the system clock by `pre`. An n-step period counter then advances once per prescaler tick. Two compare values inside each period set where the clock rises and where it falls, which makes the duty cycle programmable independently of the period. The resulting serial clock runs at f_sys / (pre * n).

Shift logic around the block does not watch the clock itself. It uses two single-cycle strobes that mark the rising and falling transitions. The configuration word may change at any time, but the divider adopts a new word only where a period ends, so a period never has mixed timing. When the top bit of the word is set, the divider is bypassed. The system clock then appears directly on the serial clock output, and both strobes stay asserted. Switching between the divided clock and the raw clock is not glitch-protected.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `sclk`, `rise_stb` and `fall_stb` are all 0.
- R2: The word is decoded as follows: bits 30:18 hold pre-1 (pre from 1 to 8192), bits 17:12 hold n-1, bits 11:6 hold h-1, and bits 5:0 hold l-1 (n, h and l each from 1 to 64).
- R3: In divided mode the serial clock repeats every pre*n system clocks.
- R4: Number the steps of a period 0 to n-1, each lasting pre system clocks. `sclk` is high exactly during steps c with h <= c <= l-1, so it stays high for pre*(l-h) clocks. With l = n, the fall coincides with the end of the period.
- R5: Every period begins at step 0 with `sclk` low. After the word is loaded, which happens on the first clock edge after reset or after leaving bypass, the first rise is seen pre*h+1 edges after the edge that releases the block.
- R6: In divided mode, `rise_stb` is 1 in exactly the first cycle in which `sclk` is high, and `fall_stb` is 1 in exactly the first cycle in which `sclk` is low again. The two strobes are never high together.
- R7: A word written in the middle of a period has no effect until that period ends. The current period completes with the old values, and the next period uses the new ones.
- R8: With bit 31 set, `sclk` follows the system clock, both strobes are held at 1, and bits 30:0 have no effect. Clearing bit 31 starts a fresh period at step 0 using the current word, with the same timing as leaving reset.
- R9: If h >= l, `sclk` stays low and neither strobe fires.
- R10: The extremes work: pre=1 with n=2 gives a 2-clock period, n=64 is usable, and pre=8192 is usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed divider configuration and bypass bit |
| sclk | output | 1 | Generated serial clock |
| rise_stb | output | 1 | One-cycle strobe marking an `sclk` rising transition |
| fall_stb | output | 1 | One-cycle strobe marking an `sclk` falling transition |

## Verification
The bench goes after the places where an off-by-one in the minus-one field encoding would show up:
- the delay to the first rise, the high time and the period, measured for the minimum setting, the n=64 setting, the maximum prescale, and random settings;
- settings where l is below n, where a design that ignores the low compare would stretch the high phase to the period end.

A configuration swap placed mid-period checks the period boundary. An eager reload would shorten or lengthen the current high or low phase.

Degenerate settings with h at or above l must keep the clock silent. A wrong comparison there would emit stray pulses.

Bypass is checked in both clock phases and with different field contents, and its exit timing is measured. A design that kept stale counter state across bypass would produce a short or long first period.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Register layout: three 6-bit step fields, a 13-bit prescale field, one bypass bit.
  localparam int SCLK_CFG_W = 32;
  localparam int SCLK_FLD_W = 6;
  localparam int SCLK_PRE_W = 13;
  localparam int SCLK_STEP_FIELDS = 3;

  // Index of each step field inside the packed word (order is decoded behaviour).
  localparam int SCLK_IDX_FALL = 0;
  localparam int SCLK_IDX_RISE = 1;
  localparam int SCLK_IDX_LEN  = 2;

  // Step counter value c (0 based) lies in the high phase when
  // rise_m1 < c <= fall_m1, i.e. h <= c <= l-1 in one-based values.
  function automatic logic sclk_in_high(input logic [31:0] cnt,
                                        input logic [31:0] rise_m1,
                                        input logic [31:0] fall_m1);
    return (cnt > rise_m1) && (cnt <= fall_m1);
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import spi_sclk_pkg::*;
#(
  parameter int CFG_W = SCLK_CFG_W,
  parameter int FLD_W = SCLK_FLD_W,
  parameter int PRE_W = SCLK_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             wrap,
  output logic             run_q,
  output logic             byp_q,
  output logic [PRE_W-1:0] act_pre,
  output logic [FLD_W-1:0] act_n,
  output logic [FLD_W-1:0] act_h,
  output logic [FLD_W-1:0] act_l,
  output logic [PRE_W-1:0] nxt_pre,
  output logic [FLD_W-1:0] nxt_n,
  output logic [FLD_W-1:0] nxt_h,
  output logic [FLD_W-1:0] nxt_l
);

  localparam int PRE_LSB = SCLK_STEP_FIELDS * FLD_W;
  localparam int BYP_BIT = CFG_W - 1;

  logic [FLD_W-1:0] step_fld [SCLK_STEP_FIELDS];
  logic             load;

  // Step fields sit back to back from bit 0 upward.
  for (genvar g = 0; g < SCLK_STEP_FIELDS; g++) begin : g_step_fld
    assign step_fld[g] = cfg_word[g*FLD_W +: FLD_W];
  end

  // Adopt a new word when idle (after reset or in bypass) or at a period end.
  assign load = ~run_q | wrap;

  always_comb begin
    if (load) begin
      nxt_pre = cfg_word[PRE_LSB +: PRE_W];
      nxt_n   = step_fld[SCLK_IDX_LEN];
      nxt_h   = step_fld[SCLK_IDX_RISE];
      nxt_l   = step_fld[SCLK_IDX_FALL];
    end else begin
      nxt_pre = act_pre;
      nxt_n   = act_n;
      nxt_h   = act_h;
      nxt_l   = act_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pre <= '0;
      act_n   <= '0;
      act_h   <= '0;
      act_l   <= '0;
      byp_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      act_pre <= nxt_pre;
      act_n   <= nxt_n;
      act_h   <= nxt_h;
      act_l   <= nxt_l;
      byp_q   <= cfg_word[BYP_BIT];
      run_q   <= ~cfg_word[BYP_BIT];
    end
  end

endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_m1,
  output logic             tick,
  output logic [PRE_W-1:0] pcnt_q
);

  logic [PRE_W-1:0] pcnt_d;

  assign tick = run && (pcnt_q == pre_m1);

  always_comb begin
    if (!run || tick) pcnt_d = '0;
    else              pcnt_d = pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/sclk_period_count.sv
module sclk_period_count #(
  parameter int FLD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [FLD_W-1:0] n_m1,
  output logic             wrap,
  output logic [FLD_W-1:0] cnt_q,
  output logic [FLD_W-1:0] cnt_d
);

  assign wrap = tick && (cnt_q == n_m1);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + FLD_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sclk_edge_out.sv
module sclk_edge_out
  import spi_sclk_pkg::*;
#(
  parameter int FLD_W = SCLK_FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp_q,
  input  logic [FLD_W-1:0] cnt_d,
  input  logic [FLD_W-1:0] h_d,
  input  logic [FLD_W-1:0] l_d,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             sclk_q,
  output logic             rise_q,
  output logic             fall_q
);

  logic lvl_d;

  // Level is decided from next-state values so sclk_q is a clean flop output.
  assign lvl_d = sclk_in_high(32'(cnt_d), 32'(h_d), 32'(l_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sclk_q <= lvl_d;
      rise_q <= lvl_d & ~sclk_q;
      fall_q <= ~lvl_d & sclk_q;
    end
  end

  assign sclk     = byp_q ? clk : sclk_q;
  assign rise_stb = byp_q | rise_q;
  assign fall_stb = byp_q | fall_q;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int CFG_W = SCLK_CFG_W,
  parameter int FLD_W = SCLK_FLD_W,
  parameter int PRE_W = SCLK_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int ACT_W = PRE_W + SCLK_STEP_FIELDS * FLD_W;

  // Named internal events for the checker.
  logic             run_q;
  logic             byp_q;
  logic             tick;
  logic             wrap;
  logic [PRE_W-1:0] pcnt_q;
  logic [FLD_W-1:0] cnt_q;
  logic [FLD_W-1:0] cnt_d;
  logic [PRE_W-1:0] act_pre;
  logic [FLD_W-1:0] act_n;
  logic [FLD_W-1:0] act_h;
  logic [FLD_W-1:0] act_l;
  logic [PRE_W-1:0] nxt_pre;
  logic [FLD_W-1:0] nxt_n;
  logic [FLD_W-1:0] nxt_h;
  logic [FLD_W-1:0] nxt_l;
  logic [ACT_W-1:0] act_bus;
  logic             sclk_q;
  logic             rise_q;
  logic             fall_q;

  assign act_bus = {act_pre, act_n, act_h, act_l};

  sclk_cfg_hold #(.CFG_W(CFG_W), .FLD_W(FLD_W), .PRE_W(PRE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .wrap     (wrap),
    .run_q    (run_q),
    .byp_q    (byp_q),
    .act_pre  (act_pre),
    .act_n    (act_n),
    .act_h    (act_h),
    .act_l    (act_l),
    .nxt_pre  (nxt_pre),
    .nxt_n    (nxt_n),
    .nxt_h    (nxt_h),
    .nxt_l    (nxt_l)
  );

  sclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .pre_m1 (act_pre),
    .tick   (tick),
    .pcnt_q (pcnt_q)
  );

  sclk_period_count #(.FLD_W(FLD_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick),
    .n_m1  (act_n),
    .wrap  (wrap),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  sclk_edge_out #(.FLD_W(FLD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .byp_q    (byp_q),
    .cnt_d    (cnt_d),
    .h_d      (nxt_h),
    .l_d      (nxt_l),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .sclk_q   (sclk_q),
    .rise_q   (rise_q),
    .fall_q   (fall_q)
  );

  // nxt_pre and nxt_n feed the flops inside u_cfg; kept visible for debug.
  logic unused_nxt;
  assign unused_nxt = ^{nxt_pre, nxt_n};

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int FLD_W = 6,
  parameter int PRE_W = 13,
  parameter int ACT_W = PRE_W + 3 * FLD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             byp_q,
  input logic             wrap,
  input logic [PRE_W-1:0] pcnt_q,
  input logic [PRE_W-1:0] act_pre,
  input logic [FLD_W-1:0] cnt_q,
  input logic [FLD_W-1:0] act_n,
  input logic [FLD_W-1:0] act_h,
  input logic [FLD_W-1:0] act_l,
  input logic [ACT_W-1:0] act_bus,
  input logic             sclk_q,
  input logic             rise_q,
  input logic             fall_q,
  input logic             rise_stb,
  input logic             fall_stb
);

  AST_STEP_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= act_n)); // R3

  AST_PRESCALE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pcnt_q <= act_pre)); // R3

  AST_CFG_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(wrap)) |-> $stable(act_bus)); // R7

  AST_PERIOD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap) |-> !sclk_q); // R5

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (sclk_q && !$past(sclk_q))); // R6

  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!sclk_q && $past(sclk_q))); // R6

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_q |-> !(rise_stb && fall_stb)); // R6

  AST_BYPASS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> (rise_stb && fall_stb)); // R8

  AST_DEGENERATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (act_h >= act_l)) |-> !rise_q); // R9

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.FLD_W(FLD_W), .PRE_W(PRE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .byp_q    (byp_q),
  .wrap     (wrap),
  .pcnt_q   (pcnt_q),
  .act_pre  (act_pre),
  .cnt_q    (cnt_q),
  .act_n    (act_n),
  .act_h    (act_h),
  .act_l    (act_l),
  .act_bus  (act_bus),
  .sclk_q   (sclk_q),
  .rise_q   (rise_q),
  .fall_q   (fall_q),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/spi_sclk_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        sclk, rise_stb, fall_stb;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  mon_en = 1'b1;
  logic prev_sclk = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  spi_sclk_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  // Requirement-derived arithmetic (one-based values).
  function automatic logic [31:0] pack(int pre, int n, int h, int l, bit byp);
    return {byp, 13'(pre - 1), 6'(n - 1), 6'(h - 1), 6'(l - 1)};
  endfunction
  function automatic int exp_first(int pre, int h);      return 1 + pre * h;     endfunction
  function automatic int exp_high(int pre, int h, int l); return pre * (l - h);  endfunction
  function automatic int exp_period(int pre, int n);     return pre * n;         endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R6: strobes line up with sclk transitions in divided mode.
  always @(negedge clk) begin
    if (!rst_n) prev_sclk = 1'b0;
    else if (mon_en) begin
      check(rise_stb == (sclk & ~prev_sclk), "R6", "rise strobe vs edge",
            rise_stb, sclk & ~prev_sclk);
      check(fall_stb == (~sclk & prev_sclk), "R6", "fall strobe vs edge",
            fall_stb, ~sclk & prev_sclk);
      prev_sclk = sclk;
    end
  end

  task automatic do_reset(logic [31:0] w, output int rel);
    rst_n = 1'b0;
    cfg_word = w;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && rise_stb == 1'b0 && fall_stb == 1'b0, "R1",
          "outputs in reset", {sclk, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    rel = cyc;
  endtask

  task automatic wait_stb(bit want_rise, int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (want_rise ? rise_stb : fall_stb) begin
        at = cyc;
        return;
      end
    end
  endtask

  task automatic run_cfg(int pre, int n, int h, int l, string req);
    int rel, r1, f1, r2, lim;
    lim = 2 * pre * n + 16;
    do_reset(pack(pre, n, h, l, 1'b0), rel);
    wait_stb(1'b1, lim, r1);
    check(r1 - rel == exp_first(pre, h), req, "R5 first rise delay", r1 - rel, exp_first(pre, h));
    wait_stb(1'b0, lim, f1);
    check(f1 - r1 == exp_high(pre, h, l), req, "R4 high time", f1 - r1, exp_high(pre, h, l));
    wait_stb(1'b1, lim, r2);
    check(r2 - r1 == exp_period(pre, n), req, "R3 period", r2 - r1, exp_period(pre, n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rel, r1, f1, r2, r3, f2, x, cnt;
    bit stuck;
    void'($urandom(32'd20250517));

    // Directed settings
    run_cfg(2, 4, 2, 4, "R2 half duty");
    run_cfg(1, 2, 1, 2, "R10 minimum");
    run_cfg(1, 64, 32, 64, "R10 n=64");
    run_cfg(3, 10, 2, 7, "R4 l below n");
    run_cfg(8192, 2, 1, 2, "R10 max prescale");

    // Random settings
    for (int k = 0; k < 10; k++) begin
      int pre, n, h, l;
      pre = 1 + $urandom_range(0, 15);
      n   = $urandom_range(2, 64);
      h   = $urandom_range(1, n - 1);
      l   = $urandom_range(h + 1, n);
      run_cfg(pre, n, h, l, "R2 random");
    end

    // R7: mid-period swap A(2,6,2,5) -> B(3,5,1,3)
    do_reset(pack(2, 6, 2, 5, 1'b0), rel);
    wait_stb(1'b1, 64, r1);
    cfg_word = pack(3, 5, 1, 3, 1'b0);
    wait_stb(1'b0, 64, f1);
    check(f1 - r1 == 6, "R7", "old high time kept", f1 - r1, 6);
    wait_stb(1'b1, 64, r2);
    check(r2 - f1 == 2 * 1 + 3 * 1, "R7", "low time across boundary", r2 - f1, 5);
    wait_stb(1'b0, 64, f2);
    check(f2 - r2 == 6, "R7", "new high time", f2 - r2, 6);
    wait_stb(1'b1, 64, r3);
    check(r3 - r2 == 15, "R7", "new period", r3 - r2, 15);

    // R9: degenerate compare settings
    do_reset(pack(1, 4, 3, 3, 1'b0), rel);
    cnt = 0; stuck = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rise_stb || fall_stb) cnt++;
      if (sclk) stuck = 1'b0;
    end
    check(cnt == 0 && stuck, "R9", "h equal l silent", cnt, 0);
    do_reset(pack(2, 8, 6, 3, 1'b0), rel);
    cnt = 0; stuck = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rise_stb || fall_stb) cnt++;
      if (sclk) stuck = 1'b0;
    end
    check(cnt == 0 && stuck, "R9", "h above l silent", cnt, 0);

    // R8: bypass
    mon_en = 1'b0;
    do_reset(pack(5, 9, 2, 7, 1'b1), rel);
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R8", "bypass sclk low phase", sclk, 0);
    check(rise_stb && fall_stb, "R8", "bypass strobes", {rise_stb, fall_stb}, 3);
    @(posedge clk); #2;
    check(sclk == 1'b1, "R8", "bypass sclk high phase", sclk, 1);
    @(negedge clk);
    cfg_word = pack(1, 2, 1, 2, 1'b1);
    repeat (2) @(negedge clk);
    check(sclk == 1'b0 && rise_stb && fall_stb, "R8", "other fields ignored low",
          {sclk, rise_stb, fall_stb}, 3);
    @(posedge clk); #2;
    check(sclk == 1'b1, "R8", "other fields ignored high", sclk, 1);
    @(negedge clk);
    cfg_word = pack(2, 4, 2, 4, 1'b0);
    x = cyc;
    @(negedge clk);
    check(!sclk && !rise_stb && !fall_stb, "R8", "exit cycle quiet",
          {sclk, rise_stb, fall_stb}, 0);
    wait_stb(1'b1, 64, r1);
    check(r1 - x == exp_first(2, 2), "R8", "first rise after exit", r1 - x, exp_first(2, 2));
    wait_stb(1'b1, 64, r2);
    check(r2 - r1 == exp_period(2, 4), "R8", "period after exit", r2 - r1, exp_period(2, 4));

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule